// File: doc/BRIEF.md
# UART Interrupt Priority and Receive Timeout Unit

This block sits beside the register file of a 16550-style serial port and turns the port's status into one interrupt request and a four-bit identification code. Five sources compete, in a fixed order: receiver line errors, received data at or above the FIFO trigger level, a receive character timeout, a pending transmit-holding-empty event, and modem-status deltas. The code is recomputed on every clock, and the code and the request are both registered.

The block also keeps three pieces of state. The first is the sticky receive error flags. They are fed by the error bits stored with the entry at the head of the receive FIFO and by an overrun event. The second is a receive timeout counter measured in clocks. The third is a one-shot flag that marks a fresh transmit-empty event. The surrounding port logic drives strobes for pushes, pops, shifter loads, register writes and register reads. It also drives the FIFO fill count, the trigger select field and the number of clocks per character.

Top module: `uirq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `iir_code` is 4'b0001, `irq` is 0, `err_flags` is 0 and no transmit-empty event is pending.
- R2: `iir_code` is registered. At each clock edge it takes the highest-priority active source, in this order: line status, data available, timeout, transmit empty, modem. It takes 4'b0001 when no source is active. `irq` is registered as well and is 1 exactly when `iir_code` is not 4'b0001.
- R3: The line-status source gives code 4'b0110. It is active when `ier[2]` is 1 and any bit of `err_flags` is 1. The bits of `err_flags` are [0] overrun, [1] parity, [2] framing, [3] break.
- R4: The data-available source gives code 4'b0100. It is active when `ier[0]` is 1, `rx_count` is non-zero, and `rx_count` is at least the trigger level chosen by `trig_sel`. The levels are 1, 4, 8 and 14 for the values 0, 1, 2 and 3.
- R5: A timeout counter adds one on each clock while `rx_count` is non-zero. It returns to 0 on an `rx_push` or `rx_pop` strobe. The timeout source gives code 4'b1100. It is active when `ier[0]` is 1, `rx_count` is non-zero, and the counter has reached 4 × `char_clks`.
- R6: The transmit-empty source gives code 4'b0010. It is active when `ier[1]` is 1, `thr_empty` is 1 and the pending flag is set. `tx_load` sets the flag. `thr_wr`, `ier_wr` and `iir_rd` clear it. When a set and a clear arrive in the same cycle, the set wins.
- R7: The modem source gives code 4'b0000. It is active when `ier[3]` is 1 and any bit of `msr_delta` is 1.
- R8: `head_err_clr` is 1 in every cycle where `rx_count` is non-zero and `head_err` is non-zero. In those cycles `head_err` is ORed into `err_flags` at the next edge. `ovr_evt` sets `err_flags[0]`. Set bits stay set until `lsr_rd`, which clears the flags in the same edge at which any new bits are added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ier | input | 4 | Source enables: [0] data/timeout, [1] transmit empty, [2] line status, [3] modem |
| trig_sel | input | 2 | Receive trigger level select |
| char_clks | input | CLK_W | Clocks per character |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_push | input | 1 | A character was added to the receive FIFO |
| rx_pop | input | 1 | A character was read from the receive FIFO |
| tx_load | input | 1 | A byte moved from the transmit FIFO into the shifter |
| thr_wr | input | 1 | Transmit holding register written |
| ier_wr | input | 1 | Enable register written |
| iir_rd | input | 1 | Identification register read |
| lsr_rd | input | 1 | Line status register read |
| ovr_evt | input | 1 | Receive overrun detected |
| thr_empty | input | 1 | Transmit holding empty status bit |
| msr_delta | input | 4 | Modem delta bits (CTS, DSR, ring trailing edge, DCD) |
| head_err | input | 4 | Error bits stored with the receive FIFO head entry |
| head_err_clr | output | 1 | Clear the error bits of the head entry |
| err_flags | output | 4 | Sticky receive error flags |
| iir_code | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
The bound assertions check every cycle for the properties that hold locally:
- the request agrees with the code;
- a line error under its enable wins the next code;
- the data-available and modem codes appear only when their enables were set;
- pushes and pops restart the timeout counter, and a shifter load arms the pending flag;
- error flags stay set and absorb the head bits.

Some behaviour only the bench's scenarios can show: the full five-way ordering when several sources are active at once, each of the four trigger levels, the exact cycle on which the timeout expires, and the one-shot behaviour of the transmit-empty flag across its three clear strobes. The bench compares every output against a behavioural model on every clock.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  typedef enum logic [3:0] {
    IID_MODEM   = 4'b0000,
    IID_NONE    = 4'b0001,
    IID_TXEMPTY = 4'b0010,
    IID_RXDATA  = 4'b0100,
    IID_LINE    = 4'b0110,
    IID_TIMEOUT = 4'b1100
  } iid_e;

  localparam int EN_RXD  = 0;
  localparam int EN_TXE  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  localparam int ERR_OVR = 0;
  localparam int ERR_W   = 4;
  localparam int MDM_W   = 4;
endpackage

// File: rtl/uirq_err_merge.sv
module uirq_err_merge
  import uirq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [ERR_W-1:0] head_err,
  input  logic             ovr_evt,
  input  logic             lsr_rd,
  output logic [ERR_W-1:0] err_flags,
  output logic             head_clr
);
  logic [ERR_W-1:0] err_q;
  logic [ERR_W-1:0] err_base;
  logic [ERR_W-1:0] err_add;

  // The head entry carries error bits only while the FIFO holds something.
  assign head_clr = (rx_count != '0) && (head_err != '0);

  always_comb begin
    err_base = lsr_rd ? '0 : err_q;
    err_add  = head_clr ? head_err : '0;
    if (ovr_evt) err_add[ERR_OVR] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= err_base | err_add;
  end

  assign err_flags = err_q;
endmodule

// File: rtl/uirq_timeout.sv
module uirq_timeout #(
  parameter int CLK_W   = 16,
  parameter int TO_MULT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CLK_W-1:0] char_clks,
  input  logic             data_ready,
  input  logic             rx_push,
  input  logic             rx_pop,
  output logic             expired,
  output logic [CLK_W+$clog2(TO_MULT):0] cnt
);
  localparam int TW = CLK_W + $clog2(TO_MULT) + 1;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] limit;
  logic          reached;

  assign limit   = TW'(char_clks) * TW'(TO_MULT);
  assign reached = (cnt_q >= limit);

  // The counter saturates at the limit, so it cannot wrap back below it.
  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (rx_push || rx_pop)  cnt_q <= '0;
    else if (data_ready && !reached) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = data_ready && reached;
  assign cnt     = cnt_q;
endmodule

// File: rtl/uirq_thre_pend.sv
module uirq_thre_pend (
  input  logic clk,
  input  logic rst,
  input  logic tx_load,
  input  logic thr_wr,
  input  logic ier_wr,
  input  logic iir_rd,
  output logic pend
);
  logic pend_q;

  // A new shifter load outranks any clear strobe in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)                            pend_q <= 1'b0;
    else if (tx_load)                   pend_q <= 1'b1;
    else if (thr_wr || ier_wr || iir_rd) pend_q <= 1'b0;
  end

  assign pend = pend_q;
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ier,
  input  logic [ERR_W-1:0] err_flags,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       trig_sel,
  input  logic             to_expired,
  input  logic             thr_empty,
  input  logic             pend,
  input  logic [MDM_W-1:0] msr_delta,
  output logic [3:0]       iir_code,
  output logic             irq
);
  localparam int NLVL = 4;
  localparam int LVL [NLVL] = '{TRIG0, TRIG1, TRIG2, TRIG3};

  logic [NLVL-1:0] lvl_hit;
  logic            src_line, src_rxd, src_to, src_txe, src_mdm;
  iid_e            code_d;
  logic [3:0]      iir_q;
  logic            irq_q;

  // One comparator per trigger level, then the select picks among them.
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign lvl_hit[g] = (rx_count >= CNT_W'(LVL[g]));
  end

  assign src_line = ier[EN_LINE] && (err_flags != '0);
  assign src_rxd  = ier[EN_RXD] && (rx_count != '0) && lvl_hit[trig_sel];
  assign src_to   = ier[EN_RXD] && to_expired;
  assign src_txe  = ier[EN_TXE] && thr_empty && pend;
  assign src_mdm  = ier[EN_MDM] && (msr_delta != '0);

  always_comb begin
    if (src_line)     code_d = IID_LINE;
    else if (src_rxd) code_d = IID_RXDATA;
    else if (src_to)  code_d = IID_TIMEOUT;
    else if (src_txe) code_d = IID_TXEMPTY;
    else if (src_mdm) code_d = IID_MODEM;
    else              code_d = IID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_q <= IID_NONE;
      irq_q <= 1'b0;
    end else begin
      iir_q <= code_d;
      irq_q <= (code_d != IID_NONE);
    end
  end

  assign iir_code = iir_q;
  assign irq      = irq_q;
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CLK_W      = 16,
  parameter int TO_MULT    = 4,
  parameter int TRIG0      = 1,
  parameter int TRIG1      = 4,
  parameter int TRIG2      = 8,
  parameter int TRIG3      = 14,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ier,
  input  logic [1:0]       trig_sel,
  input  logic [CLK_W-1:0] char_clks,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             tx_load,
  input  logic             thr_wr,
  input  logic             ier_wr,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             ovr_evt,
  input  logic             thr_empty,
  input  logic [3:0]       msr_delta,
  input  logic [3:0]       head_err,
  output logic             head_err_clr,
  output logic [3:0]       err_flags,
  output logic [3:0]       iir_code,
  output logic             irq
);
  localparam int TW = CLK_W + $clog2(TO_MULT) + 1;

  logic          data_ready;
  logic          to_expired;
  logic [TW-1:0] to_cnt;
  logic          thre_pend;

  assign data_ready = (rx_count != '0);

  uirq_err_merge #(.CNT_W(CNT_W)) u_err (
    .clk       (clk),
    .rst       (rst),
    .rx_count  (rx_count),
    .head_err  (head_err),
    .ovr_evt   (ovr_evt),
    .lsr_rd    (lsr_rd),
    .err_flags (err_flags),
    .head_clr  (head_err_clr)
  );

  uirq_timeout #(.CLK_W(CLK_W), .TO_MULT(TO_MULT)) u_to (
    .clk        (clk),
    .rst        (rst),
    .char_clks  (char_clks),
    .data_ready (data_ready),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .expired    (to_expired),
    .cnt        (to_cnt)
  );

  uirq_thre_pend u_pend (
    .clk     (clk),
    .rst     (rst),
    .tx_load (tx_load),
    .thr_wr  (thr_wr),
    .ier_wr  (ier_wr),
    .iir_rd  (iir_rd),
    .pend    (thre_pend)
  );

  uirq_prio #(
    .CNT_W(CNT_W), .TRIG0(TRIG0), .TRIG1(TRIG1), .TRIG2(TRIG2), .TRIG3(TRIG3)
  ) u_prio (
    .clk        (clk),
    .rst        (rst),
    .ier        (ier),
    .err_flags  (err_flags),
    .rx_count   (rx_count),
    .trig_sel   (trig_sel),
    .to_expired (to_expired),
    .thr_empty  (thr_empty),
    .pend       (thre_pend),
    .msr_delta  (msr_delta),
    .iir_code   (iir_code),
    .irq        (irq)
  );
endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk #(
  parameter int CNT_W = 5,
  parameter int TW    = 19
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       ier,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_push,
  input logic             rx_pop,
  input logic             tx_load,
  input logic [3:0]       head_err,
  input logic             head_err_clr,
  input logic             lsr_rd,
  input logic [3:0]       err_flags,
  input logic [3:0]       iir_code,
  input logic             irq,
  input logic [TW-1:0]    to_cnt,
  input logic             thre_pend
);
  // R2: request and code agree
  p_irq_code_r2: assert property (@(posedge clk) disable iff (rst)
    irq == (iir_code != 4'b0001));

  // R1: reset state appears on the first cycle after reset
  p_reset_state_r1: assert property (@(posedge clk)
    $fell(rst) |-> (iir_code == 4'b0001 && !irq && err_flags == 4'd0 && !thre_pend));

  // R3: an enabled line error owns the next code
  p_line_first_r3: assert property (@(posedge clk) disable iff (rst)
    (ier[2] && err_flags != 4'd0) |=> iir_code == 4'b0110);

  // R4: data-available code needs its enable and data
  p_rxd_enabled_r4: assert property (@(posedge clk) disable iff (rst)
    (iir_code == 4'b0100) |-> ($past(ier[0]) && $past(rx_count) != '0));

  // R5: push or pop restarts the timeout count
  p_to_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_push || rx_pop) |=> to_cnt == '0);

  // R6: a shifter load arms the pending flag
  p_pend_set_r6: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> thre_pend);

  // R7: modem code only under its enable
  p_mdm_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    (iir_code == 4'b0000) |-> $past(ier[3]));

  // R8: flags stay set without a status read
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !lsr_rd |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R8: head bits land in the flags after a clear strobe
  p_head_merge_r8: assert property (@(posedge clk) disable iff (rst)
    head_err_clr |=> ((err_flags & $past(head_err)) == $past(head_err)));
endmodule

bind uirq_ctrl uirq_ctrl_chk #(.CNT_W(CNT_W), .TW(TW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ier          (ier),
  .rx_count     (rx_count),
  .rx_push      (rx_push),
  .rx_pop       (rx_pop),
  .tx_load      (tx_load),
  .head_err     (head_err),
  .head_err_clr (head_err_clr),
  .lsr_rd       (lsr_rd),
  .err_flags    (err_flags),
  .iir_code     (iir_code),
  .irq          (irq),
  .to_cnt       (to_cnt),
  .thre_pend    (thre_pend)
);

// File: tb/sim_uirq_ctrl.sv
module sim_uirq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ier = '0;
  logic [1:0]  trig_sel = '0;
  logic [15:0] char_clks = 16'd100;
  logic [4:0]  rx_count = '0;
  logic        rx_push = 0, rx_pop = 0, tx_load = 0, thr_wr = 0, ier_wr = 0;
  logic        iir_rd = 0, lsr_rd = 0, ovr_evt = 0, thr_empty = 0;
  logic [3:0]  msr_delta = '0, head_err = '0;
  logic        head_err_clr, irq;
  logic [3:0]  err_flags, iir_code;

  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  uirq_ctrl u0 (
    .clk(clk), .rst(rst), .ier(ier), .trig_sel(trig_sel), .char_clks(char_clks),
    .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop), .tx_load(tx_load),
    .thr_wr(thr_wr), .ier_wr(ier_wr), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
    .ovr_evt(ovr_evt), .thr_empty(thr_empty), .msr_delta(msr_delta),
    .head_err(head_err), .head_err_clr(head_err_clr), .err_flags(err_flags),
    .iir_code(iir_code), .irq(irq)
  );

  // Behavioural reference
  int         m_cnt = 0;
  bit         m_pend = 0;
  logic [3:0] m_err = '0;
  logic [3:0] m_iir = 4'b0001;

  function automatic int trig_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cnt = 0; m_pend = 0; m_err = '0; m_iir = 4'b0001;
    end else begin
      bit rdy;
      logic [3:0] nx;
      rdy = (rx_count != 0);
      if (ier[2] && m_err != 0) m_iir = 4'b0110;
      else if (ier[0] && rdy && int'(rx_count) >= trig_of(trig_sel)) m_iir = 4'b0100;
      else if (ier[0] && rdy && m_cnt >= 4 * int'(char_clks)) m_iir = 4'b1100;
      else if (ier[1] && thr_empty && m_pend) m_iir = 4'b0010;
      else if (ier[3] && msr_delta != 0) m_iir = 4'b0000;
      else m_iir = 4'b0001;
      nx = lsr_rd ? 4'd0 : m_err;
      if (rdy) nx = nx | head_err;
      if (ovr_evt) nx[0] = 1'b1;
      m_err = nx;
      if (rx_push || rx_pop) m_cnt = 0;
      else if (rdy) m_cnt++;
      if (tx_load) m_pend = 1;
      else if (thr_wr || ier_wr || iir_rd) m_pend = 0;
    end
  end

  // Per-clock comparison with the model
  always @(negedge clk) begin
    if (!rst) begin
      tests++;
      if (iir_code !== m_iir) begin
        fails++; $display("FAIL R2 iir_code=%h expected %h at cycle %0d", iir_code, m_iir, cyc);
      end
      tests++;
      if (irq !== (m_iir != 4'b0001)) begin
        fails++; $display("FAIL R2 irq=%b expected %b", irq, (m_iir != 4'b0001));
      end
      tests++;
      if (err_flags !== m_err) begin
        fails++; $display("FAIL R8 err_flags=%h expected %h", err_flags, m_err);
      end
      tests++;
      if (head_err_clr !== (rx_count != 0 && head_err != 0)) begin
        fails++; $display("FAIL R8 head_err_clr=%b expected %b", head_err_clr,
                          (rx_count != 0 && head_err != 0));
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_clear();
    rx_push = 0; rx_pop = 0; tx_load = 0; thr_wr = 0; ier_wr = 0;
    iir_rd = 0; lsr_rd = 0; ovr_evt = 0;
  endtask

  task automatic chk(input logic [3:0] exp, input string tag);
    tests++;
    if (iir_code !== exp) begin
      fails++; $display("FAIL %s iir_code=%h expected %h", tag, iir_code, exp);
    end
  endtask

  task automatic chk_err(input logic [3:0] exp, input string tag);
    tests++;
    if (err_flags !== exp) begin
      fails++; $display("FAIL %s err_flags=%h expected %h", tag, err_flags, exp);
    end
  endtask

  initial begin
    step(3);
    // R1: reset values while held and just after release
    tests++;
    if (iir_code !== 4'b0001 || irq !== 1'b0 || err_flags !== 4'd0) begin
      fails++; $display("FAIL R1 iir=%h irq=%b err=%h expected 1 0 0", iir_code, irq, err_flags);
    end
    rst = 0;
    step(1);
    chk(4'b0001, "R1");

    // R3 / R8: head error merged while disabled, then enabled
    rx_count = 5'd1; head_err = 4'b0100;
    step(1);
    head_err = 4'd0; rx_count = 5'd0;
    step(2);
    chk_err(4'b0100, "R8");
    chk(4'b0001, "R3");
    ier = 4'b0100;
    step(2);
    chk(4'b0110, "R3");
    lsr_rd = 1; step(1); pulse_clear();
    step(2);
    chk_err(4'd0, "R8");
    chk(4'b0001, "R3");
    ovr_evt = 1; step(1); pulse_clear();
    step(2);
    chk_err(4'b0001, "R8");
    chk(4'b0110, "R3");
    lsr_rd = 1; step(1); pulse_clear(); step(2);

    // R4: trigger levels
    ier = 4'b0001; char_clks = 16'd1000; trig_sel = 2'd1;
    rx_count = 5'd3; rx_push = 1; step(1); pulse_clear();
    step(2);
    chk(4'b0001, "R4");
    rx_count = 5'd4; step(2);
    chk(4'b0100, "R4");
    trig_sel = 2'd3; rx_count = 5'd13; step(2);
    chk(4'b0001, "R4");
    rx_count = 5'd14; step(2);
    chk(4'b0100, "R4");
    trig_sel = 2'd0; rx_count = 5'd1; step(2);
    chk(4'b0100, "R4");
    trig_sel = 2'd2; rx_count = 5'd7; step(2);
    chk(4'b0001, "R4");

    // R5: timeout after 4 character times
    char_clks = 16'd3; rx_count = 5'd1; rx_push = 1; step(1); pulse_clear();
    step(8);
    chk(4'b0001, "R5");
    step(6);
    chk(4'b1100, "R5");
    rx_pop = 1; step(1); pulse_clear();
    step(1);
    chk(4'b0001, "R5");
    rx_count = 5'd0; rx_pop = 1; step(1); pulse_clear(); step(2);

    // R6: transmit-empty one-shot
    ier = 4'b0010; thr_empty = 1;
    step(2);
    chk(4'b0001, "R6");
    tx_load = 1; step(1); pulse_clear(); step(1);
    chk(4'b0010, "R6");
    iir_rd = 1; step(1); pulse_clear(); step(1);
    chk(4'b0001, "R6");
    tx_load = 1; step(1); pulse_clear(); step(1);
    thr_wr = 1; step(1); pulse_clear(); step(1);
    chk(4'b0001, "R6");
    tx_load = 1; step(1); pulse_clear(); step(1);
    ier_wr = 1; step(1); pulse_clear(); step(1);
    chk(4'b0001, "R6");
    tx_load = 1; iir_rd = 1; step(1); pulse_clear(); step(1);
    chk(4'b0010, "R6");

    // R7: modem deltas
    ier = 4'b1000; msr_delta = 4'b0010; step(2);
    chk(4'b0000, "R7");
    tests++;
    if (irq !== 1'b1) begin fails++; $display("FAIL R7 irq=%b expected 1", irq); end
    msr_delta = 4'd0; step(2);
    chk(4'b0001, "R7");

    // R2: all sources together, peeled one by one
    ier = 4'b1111; msr_delta = 4'b1000; thr_empty = 1;
    tx_load = 1; ovr_evt = 1; char_clks = 16'd1; trig_sel = 2'd0;
    rx_count = 5'd2; rx_push = 1; step(1); pulse_clear();
    step(2);
    chk(4'b0110, "R2");
    lsr_rd = 1; step(1); pulse_clear(); step(1);
    chk(4'b0100, "R2");
    trig_sel = 2'd3; step(6);
    chk(4'b1100, "R2");
    rx_count = 5'd0; rx_pop = 1; step(1); pulse_clear(); step(1);
    chk(4'b0010, "R2");
    iir_rd = 1; step(1); pulse_clear(); step(1);
    chk(4'b0000, "R2");
    msr_delta = 4'd0; step(2);
    chk(4'b0001, "R2");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule